// File: doc/BRIEF.md
# Serial Byte Transmitter with Break and Idle-Frame Queueing

This block turns bytes into an asynchronous serial stream. Software writes bytes and a small control word through a byte-wide write port. Each byte becomes a frame: one low start bit, the data bits least significant first, and one high stop bit. The line moves to its next bit once per pulse on `bit_tick`, which an external divider supplies.

Two out-of-band frames can be requested. Clearing and then setting the enable bit while a frame is on the line queues an idle frame of all ones behind that frame. Dropping the break bit queues a break frame behind the current one. While the break bit is held, break frames repeat with no gap between them. When the transmitter is first enabled from rest, the line stays high for one bit time before anything else goes out.

Two flags report progress: holding register empty, and transmission complete. A registered interrupt request combines each flag with its own enable bit.

Top module: `serial_tx_top`

## Requirements
- R1: After reset the control word is zero, `txd` is 1, `tx_empty` is 1, `tx_done` is 1 and `irq` is 0.
- R2: A write with `wr_addr`=0 loads a byte. A data frame is sent as `txd`=0, then data bits 0..7, then `txd`=1, one bit per `bit_tick`. `txd` changes only in the clock after a tick. A byte written before the current frame's last bit finishes follows with no gap.
- R3: A control write (`wr_addr`=1) that sets enable (bit 0) from 0 to 1 while the line is at rest makes the next frame slot hold the line at 1 for exactly one bit time before any other frame.
- R4: While enable is 0 no new frame starts, `txd` stays 1 once the current frame ends, and a held byte stays held with `tx_empty`=0.
- R5: Enable written 1→0→1 while a frame is in progress queues an idle frame (10 bit times at 1) that starts when that frame ends and comes before any held byte.
- R6: Break (control bit 1) written 1→0 queues one break frame (10 bit times at 0, then 1 bit time at 1) after the current frame.
- R7: While break is 1 and enable is 1, break frames follow each other with no gap and a held byte waits.
- R8: `tx_empty` clears in the clock after a data write and sets when the held byte moves into the shifter.
- R9: `tx_done` sets when a frame ends and no frame follows it in that slot. A data write clears it.
- R10: `irq` equals, one clock later, (control bit 2 AND `tx_empty`) OR (control bit 3 AND `tx_done`).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 1 | 0 selects the data register, 1 selects the control register |
| wr_data | input | DATA_W | Write data; control uses bits 0 (enable), 1 (break), 2 (empty interrupt enable), 3 (complete interrupt enable) |
| bit_tick | input | 1 | One-clock pulse per bit time |
| txd | output | 1 | Serial output |
| tx_empty | output | 1 | Holding register empty |
| tx_done | output | 1 | Transmission complete |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with the default `DATA_W`=8. With that width, every one of the 256 byte values can go out as back-to-back frames, with each frame compared against a pattern computed from the byte. The short frames also make it cheap to capture whole sequences bit by bit. These sequences cover an idle frame between two bytes, a pulsed break, three chained breaks with a held byte waiting behind them, and the single rest bit after enabling. Interrupt combinations are exercised by toggling each enable against known flag states.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;

  typedef enum logic [2:0] {
    FK_NONE,
    FK_LEAD,
    FK_PRE,
    FK_BRK,
    FK_DATA
  } frame_kind_e;

  typedef struct packed {
    logic ie_done;
    logic ie_empty;
    logic brk;
    logic tx_en;
  } tx_ctrl_t;

  localparam int unsigned CTRL_W = 4;

endpackage

// File: rtl/serial_tx_regs.sv
module serial_tx_regs
  import serial_tx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy,
  input  logic              take_lead,
  input  logic              take_pre,
  input  logic              take_brk,
  input  logic              take_data,
  output tx_ctrl_t          ctrl,
  output logic [DATA_W-1:0] thr,
  output logic              thr_full,
  output logic              pend_lead,
  output logic              pend_pre,
  output logic              pend_brk,
  output logic              data_wr
);

  tx_ctrl_t ctrl_new;
  logic     ctrl_wr;
  logic     en_rise;
  logic     brk_fall;

  assign data_wr  = wr_en && !wr_addr;
  assign ctrl_wr  = wr_en && wr_addr;
  assign ctrl_new = tx_ctrl_t'(wr_data[CTRL_W-1:0]);
  assign en_rise  = ctrl_wr && ctrl_new.tx_en && !ctrl.tx_en;
  assign brk_fall = ctrl_wr && !ctrl_new.brk && ctrl.brk;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
    end else if (ctrl_wr) begin
      ctrl <= ctrl_new;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      thr      <= '0;
      thr_full <= 1'b0;
    end else if (data_wr) begin
      thr      <= wr_data;
      thr_full <= 1'b1;
    end else if (take_data) begin
      thr_full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_lead <= 1'b0;
      pend_pre  <= 1'b0;
      pend_brk  <= 1'b0;
    end else begin
      if (en_rise && !busy)     pend_lead <= 1'b1;
      else if (take_lead)       pend_lead <= 1'b0;
      if (en_rise && busy)      pend_pre  <= 1'b1;
      else if (take_pre)        pend_pre  <= 1'b0;
      if (brk_fall)             pend_brk  <= 1'b1;
      else if (take_brk)        pend_brk  <= 1'b0;
    end
  end

  p_lead_queued_r3: assert property (@(posedge clk) disable iff (rst)
    (en_rise && !busy) |=> pend_lead);

  p_pre_queued_r5: assert property (@(posedge clk) disable iff (rst)
    (en_rise && busy) |=> pend_pre);

  p_brk_queued_r6: assert property (@(posedge clk) disable iff (rst)
    brk_fall |=> pend_brk);

endmodule

// File: rtl/serial_tx_seq.sv
module serial_tx_seq
  import serial_tx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_tick,
  input  tx_ctrl_t          ctrl,
  input  logic              pend_lead,
  input  logic              pend_pre,
  input  logic              pend_brk,
  input  logic              thr_full,
  input  logic [DATA_W-1:0] thr,
  output logic              txd,
  output logic              busy,
  output logic              take_lead,
  output logic              take_pre,
  output logic              take_brk,
  output logic              take_data,
  output logic              idle_done
);

  localparam int unsigned FR_W  = DATA_W + 3;
  localparam int unsigned CNT_W = $clog2(FR_W + 1);
  localparam int unsigned WORD_LEN = DATA_W + 2;

  logic [FR_W-1:0]  sh;
  logic [FR_W-1:0]  fr;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] flen;
  logic             slot;
  logic             frame_end;
  frame_kind_e      kind;

  assign slot      = bit_tick && (!busy || (cnt == '0));
  assign frame_end = bit_tick && busy && (cnt == '0);

  always_comb begin
    kind = FK_NONE;
    if (slot && ctrl.tx_en) begin
      if (pend_lead)                  kind = FK_LEAD;
      else if (pend_pre)              kind = FK_PRE;
      else if (ctrl.brk || pend_brk)  kind = FK_BRK;
      else if (thr_full)              kind = FK_DATA;
    end
  end

  always_comb begin
    fr   = '1;
    flen = CNT_W'(1);
    case (kind)
      FK_LEAD: begin
        fr   = '1;
        flen = CNT_W'(1);
      end
      FK_PRE: begin
        fr   = '1;
        flen = CNT_W'(WORD_LEN);
      end
      FK_BRK: begin
        fr   = {1'b1, {(FR_W-1){1'b0}}};
        flen = CNT_W'(FR_W);
      end
      FK_DATA: begin
        fr   = {2'b11, thr, 1'b0};
        flen = CNT_W'(WORD_LEN);
      end
      default: begin
        fr   = '1;
        flen = CNT_W'(1);
      end
    endcase
  end

  assign take_lead = (kind == FK_LEAD);
  assign take_pre  = (kind == FK_PRE);
  assign take_brk  = (kind == FK_BRK);
  assign take_data = (kind == FK_DATA);
  assign idle_done = frame_end && (kind == FK_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      txd  <= 1'b1;
      sh   <= '1;
      cnt  <= '0;
    end else if (slot) begin
      if (kind != FK_NONE) begin
        busy <= 1'b1;
        txd  <= fr[0];
        sh   <= {1'b1, fr[FR_W-1:1]};
        cnt  <= flen - CNT_W'(1);
      end else begin
        busy <= 1'b0;
        txd  <= 1'b1;
        sh   <= '1;
        cnt  <= '0;
      end
    end else if (bit_tick && busy) begin
      txd <= sh[0];
      sh  <= {1'b1, sh[FR_W-1:1]};
      cnt <= cnt - CNT_W'(1);
    end
  end

  p_idle_line_high_r4: assert property (@(posedge clk) disable iff (rst)
    !busy |-> txd);

  p_no_start_disabled_r4: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.tx_en && !busy) |=> !busy);

  p_start_bit_low_r2: assert property (@(posedge clk) disable iff (rst)
    take_data |=> !txd);

  p_line_moves_on_tick_r2: assert property (@(posedge clk) disable iff (rst)
    !bit_tick |=> $stable(txd));

  p_break_starts_low_r7: assert property (@(posedge clk) disable iff (rst)
    take_brk |=> !txd);

endmodule

// File: rtl/serial_tx_flags.sv
module serial_tx_flags
  import serial_tx_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  tx_ctrl_t ctrl,
  input  logic     data_wr,
  input  logic     take_data,
  input  logic     idle_done,
  output logic     tx_empty,
  output logic     tx_done,
  output logic     irq
);

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_empty <= 1'b1;
      tx_done  <= 1'b1;
    end else begin
      if (data_wr)        tx_empty <= 1'b0;
      else if (take_data) tx_empty <= 1'b1;
      if (data_wr)        tx_done  <= 1'b0;
      else if (idle_done) tx_done  <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= (ctrl.ie_empty && tx_empty) || (ctrl.ie_done && tx_done);
  end

  p_empty_clears_r8: assert property (@(posedge clk) disable iff (rst)
    data_wr |=> !tx_empty);

  p_done_clears_r9: assert property (@(posedge clk) disable iff (rst)
    data_wr |=> !tx_done);

  p_done_sets_r9: assert property (@(posedge clk) disable iff (rst)
    (idle_done && !data_wr) |=> tx_done);

  p_irq_follows_r10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == $past((ctrl.ie_empty && tx_empty) || (ctrl.ie_done && tx_done))));

endmodule

// File: rtl/serial_tx_top.sv
module serial_tx_top
  import serial_tx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              bit_tick,
  output logic              txd,
  output logic              tx_empty,
  output logic              tx_done,
  output logic              irq
);

  tx_ctrl_t          ctrl;
  logic [DATA_W-1:0] thr;
  logic              thr_full;
  logic              pend_lead;
  logic              pend_pre;
  logic              pend_brk;
  logic              data_wr;
  logic              busy;
  logic              take_lead;
  logic              take_pre;
  logic              take_brk;
  logic              take_data;
  logic              idle_done;

  serial_tx_regs #(.DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .busy      (busy),
    .take_lead (take_lead),
    .take_pre  (take_pre),
    .take_brk  (take_brk),
    .take_data (take_data),
    .ctrl      (ctrl),
    .thr       (thr),
    .thr_full  (thr_full),
    .pend_lead (pend_lead),
    .pend_pre  (pend_pre),
    .pend_brk  (pend_brk),
    .data_wr   (data_wr)
  );

  serial_tx_seq #(.DATA_W(DATA_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .bit_tick  (bit_tick),
    .ctrl      (ctrl),
    .pend_lead (pend_lead),
    .pend_pre  (pend_pre),
    .pend_brk  (pend_brk),
    .thr_full  (thr_full),
    .thr       (thr),
    .txd       (txd),
    .busy      (busy),
    .take_lead (take_lead),
    .take_pre  (take_pre),
    .take_brk  (take_brk),
    .take_data (take_data),
    .idle_done (idle_done)
  );

  serial_tx_flags u_flags (
    .clk       (clk),
    .rst       (rst),
    .ctrl      (ctrl),
    .data_wr   (data_wr),
    .take_data (take_data),
    .idle_done (idle_done),
    .tx_empty  (tx_empty),
    .tx_done   (tx_done),
    .irq       (irq)
  );

endmodule

// File: tb/test_serial_tx_top.sv
module test_serial_tx_top;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic          wr_addr = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          bit_tick = 1'b0;
  logic          txd, tx_empty, tx_done, irq;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;

  logic exp_q [0:127];
  logic got_q [0:127];
  int   n_exp, n_got;

  serial_tx_top #(.DATA_W(DW)) i_serial_tx_top (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .bit_tick(bit_tick), .txd(txd), .tx_empty(tx_empty), .tx_done(tx_done), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic wr(input logic a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tick(output logic b);
    @(negedge clk);
    bit_tick = 1'b1;
    @(negedge clk);
    bit_tick = 1'b0;
    b = txd;
    @(negedge clk);
  endtask

  task automatic cap(input int n);
    logic b;
    for (int i = 0; i < n; i++) begin
      tick(b);
      got_q[n_got] = b;
      n_got++;
    end
  endtask

  task automatic push_bit(input logic b);
    exp_q[n_exp] = b;
    n_exp++;
  endtask

  task automatic push_frame(input logic [DW-1:0] v);
    push_bit(1'b0);
    for (int i = 0; i < DW; i++) push_bit(v[i]);
    push_bit(1'b1);
  endtask

  task automatic push_ones(input int n);
    for (int i = 0; i < n; i++) push_bit(1'b1);
  endtask

  task automatic push_brk();
    for (int i = 0; i < DW + 2; i++) push_bit(1'b0);
    push_bit(1'b1);
  endtask

  task automatic cmp_stream(input string req);
    int bad_at;
    bad_at = -1;
    for (int i = 0; i < n_exp; i++)
      if (bad_at < 0 && got_q[i] !== exp_q[i]) bad_at = i;
    n_cmp++;
    if (n_got != n_exp || bad_at >= 0) begin
      n_bad++;
      if (bad_at >= 0)
        $display("FAIL %s bit %0d actual=%0b expected=%0b", req, bad_at, got_q[bad_at], exp_q[bad_at]);
      else
        $display("FAIL %s length actual=%0d expected=%0d", req, n_got, n_exp);
    end
    n_exp = 0;
    n_got = 0;
  endtask

  initial begin
    logic [9:0] fr;
    logic b;
    n_exp = 0;
    n_got = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 txd", 32'(txd), 1);
    chk("R1 empty", 32'(tx_empty), 1);
    chk("R1 done", 32'(tx_done), 1);
    chk("R1 irq", 32'(irq), 0);
    // R4: reset control has enable off, a byte must not start
    wr(1'b0, 8'hC3);
    cap(3);
    push_ones(3);
    cmp_stream("R4 disabled after reset");
    chk("R4 held byte empty", 32'(tx_empty), 0);

    // R3: enable from rest gives one high bit, then the held byte
    wr(1'b1, 8'h01);
    cap(12);
    push_ones(1); push_frame(8'hC3); push_ones(1);
    cmp_stream("R3 lead bit then frame");
    chk("R9 done after frame", 32'(tx_done), 1);
    chk("R8 empty after load", 32'(tx_empty), 1);

    // R2/R8: sweep all byte values back to back
    wr(1'b0, 8'h00);
    chk("R9 done cleared", 32'(tx_done), 0);
    for (int v = 0; v < 256; v++) begin
      fr = '0;
      tick(b);
      fr[0] = b;
      chk("R8 empty on load", 32'(tx_empty), 1);
      if (v < 255) begin
        wr(1'b0, 8'(v + 1));
        chk("R8 empty cleared", 32'(tx_empty), 0);
      end
      for (int i = 1; i < 10; i++) begin
        tick(b);
        fr[i] = b;
      end
      chk("R2 frame", 32'(fr), 32'({1'b1, 8'(v), 1'b0}));
    end
    chk("R9 done before last end", 32'(tx_done), 0);
    tick(b);
    chk("R2 idle after sweep", 32'(b), 1);
    chk("R9 done after sweep", 32'(tx_done), 1);

    // R5: enable pulse during a frame queues an idle frame
    wr(1'b0, 8'hA5);
    cap(1);
    wr(1'b1, 8'h00);
    wr(1'b1, 8'h01);
    wr(1'b0, 8'h3C);
    cap(30);
    push_frame(8'hA5); push_ones(10); push_frame(8'h3C); push_ones(1);
    cmp_stream("R5 idle frame queued");

    // R6: break pulse during a frame queues one break
    wr(1'b0, 8'h96);
    cap(1);
    wr(1'b1, 8'h03);
    wr(1'b1, 8'h01);
    wr(1'b0, 8'h69);
    cap(31);
    push_frame(8'h96); push_brk(); push_frame(8'h69); push_ones(1);
    cmp_stream("R6 break after current frame");

    // R7: held break repeats, byte waits, release adds one more
    wr(1'b1, 8'h03);
    wr(1'b0, 8'h5A);
    cap(15);
    wr(1'b1, 8'h01);
    cap(29);
    push_brk(); push_brk(); push_brk(); push_frame(8'h5A); push_ones(1);
    cmp_stream("R7 chained breaks then byte");

    // R4: disable, byte stays held, line high
    wr(1'b1, 8'h00);
    wr(1'b0, 8'hE7);
    cap(5);
    push_ones(5);
    cmp_stream("R4 disabled line");
    chk("R4 empty stays clear", 32'(tx_empty), 0);
    wr(1'b1, 8'h01);
    cap(12);
    push_ones(1); push_frame(8'hE7); push_ones(1);
    cmp_stream("R3 re-enable lead bit");

    // R10: interrupt combinations
    wr(1'b1, 8'h01);
    @(negedge clk);
    chk("R10 no enables", 32'(irq), 0);
    wr(1'b1, 8'h09);
    @(negedge clk);
    chk("R10 done enable", 32'(irq), 1);
    wr(1'b1, 8'h05);
    @(negedge clk);
    chk("R10 empty enable", 32'(irq), 1);
    wr(1'b0, 8'h42);
    @(negedge clk);
    chk("R10 cleared by write", 32'(irq), 0);
    wr(1'b1, 8'h0D);
    @(negedge clk);
    chk("R10 both enables flags clear", 32'(irq), 0);
    tick(b);
    chk("R10 empty after load", 32'(irq), 1);
    wr(1'b1, 8'h09);
    @(negedge clk);
    chk("R10 done enable mid frame", 32'(irq), 0);
    cap(10);
    @(negedge clk);
    chk("R10 done at end", 32'(irq), 1);
    chk("R9 done at end", 32'(tx_done), 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule